// File: doc/BRIEF.md
# Four-Rail Power Sequencer

This block brings four supply rails up and down in a programmed order. Each rail is switched by a gate-enable output. Rails come on only after an enable input is active and all four undervoltage-good flags are high. The conditions must then hold for a qualification interval. After that, a separate on-delay counter for each rail starts at the same moment, and each rail's gate asserts when its own counter runs out. A per-rail ramp time models the gate reaching full drive. When every rail is at full drive, a settle interval runs, and then the active-low sequence-complete reset is released.

Dropping the enable shuts the rails down in order. The sequence-complete reset goes low first. Then per-rail off-delay counters start together, and each gate drops when its counter expires. The block also shares an open-drain, wired-AND system-reset line with other sequencers. It releases that line while its start conditions hold and pulls it low again when the last rail goes off. If a rail's undervoltage flag stays low longer than the glitch-filter time, the block drops all rails at once and pulses them to fast discharge. The same happens if another device pulls the shared line low. If the shared line reads high while this block is still pulling it down, the line is being forced high, and the qualification wait is skipped.

All intervals are parameters counted in clock cycles. The defaults are derived from the clock rate in kHz. The on, off and ramp counts are per-rail parameters loaded into registers at reset. The enable polarity is chosen at build time.

Top module: `rail_sequencer`

## Requirements
- R1: During and right after reset, all gate and discharge outputs are 0, the sequence-complete reset output is 0 and the shared-line pull-down request is 1.
- R2: Once enable is active and all four undervoltage flags are 1, the pull-down request drops to 0 within 5 cycles. No gate asserts until at least QUAL_CYC cycles after enable went active.
- R3: All four on-delay counters start in the same cycle, so the rise of gate i minus the rise of gate 0 equals ON[i] minus ON[0] exactly.
- R4: The sequence-complete reset rises between RAMP+SETTLE_CYC and RAMP+SETTLE_CYC+5 cycles after the rise of the gate whose on-delay plus ramp is largest. RAMP is that gate's ramp count.
- R5: An undervoltage flag held low for fewer than FILT_CYC consecutive cycles has no effect. The gates stay on, the discharge outputs stay 0 and the sequence-complete reset stays 1.
- R6: An undervoltage flag held low for FILT_CYC cycles or more while rails are on is a fault. All gates drop, the sequence-complete reset drops and the pull-down request rises, all in the same cycle, and every discharge output goes to 1.
- R7: After enable goes inactive from the running state, the sequence-complete reset falls before any gate. Gate i falls OFF[i] minus OFF[0] cycles after gate 0. The pull-down request rises in the same cycle as the last gate falls.
- R8: The shared line read low while rails are on drops all gates and the sequence-complete reset, and no rail comes back while enable stays inactive.
- R9: If the shared line reads high while the block is still requesting pull-down and the start conditions hold, the first gate rises sooner than QUAL_CYC cycles after enable.
- R10: With EN_ACTIVE_LOW=1 the enable input counts as active when 0. With the input at 1 the pull-down request stays 1.
- R11: Enable going inactive during the staggered turn-on shuts down the gates that are on through their off delays. Gates still waiting never rise.
- R12: After a fault the rails stay off, even once the flags are good again, until enable goes inactive and then active again. A full turn-on then follows, with the discharge outputs back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sequencing enable, polarity set by EN_ACTIVE_LOW |
| uv_ok_i | input | NCH | Per-rail undervoltage-good flags |
| sysrst_sense_i | input | 1 | Sensed level of the shared wired-AND reset line |
| gate_o | output | NCH | Per-rail gate enable |
| dis_o | output | NCH | Per-rail fast-discharge strobe |
| sysrst_pd_o | output | 1 | Open-drain pull-down request for the shared line |
| seq_rst_no | output | 1 | Active-low sequence-complete reset |

## Verification
The hardest situation to reach is the turn-on that skips qualification. It needs the shared line to read high while this block is still asking to pull it low, which no correct wired-AND line does by itself. The bench models the line as the inverse of the OR of all pull-down requests, with a separate force-high override. It raises that override before enable goes active and releases it once the first gate is seen. A second hard case is enable dropping mid-stagger. The bench polls for the second-earliest gate and drops enable at once, so the later gates are caught while their counters are still running.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_QUAL,
      SQ_STAGGER,
      SQ_SETTLE,
      SQ_RUN,
      SQ_DRAIN,
      SQ_TRIP
   } seq_st_t;

   typedef enum logic [2:0] {
      CH_OFF,
      CH_WAIT_ON,
      CH_RAMP,
      CH_FULL,
      CH_WAIT_OFF
   } ch_st_t;

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pipe_q <= {STAGES{RST_VAL}};
            end else begin
               pipe_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rseq_uv_filter.sv
module rseq_uv_filter #(
   parameter int unsigned FILT_CYC = 350
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic good_o
);

   localparam int unsigned CW = $clog2(FILT_CYC + 1);

   generate
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("rseq_uv_filter: FILT_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] low_cnt_q;
   logic          good_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         low_cnt_q <= '0;
         good_q    <= 1'b0;
      end else if (raw_i) begin
         low_cnt_q <= '0;
         good_q    <= 1'b1;
      end else if (low_cnt_q == CW'(FILT_CYC - 1)) begin
         good_q    <= 1'b0;
      end else begin
         low_cnt_q <= low_cnt_q + 1'b1;
      end
   end

   assign good_o = good_q;

   assert_fall_needs_low_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(good_o) |-> $past(!raw_i));

   assert_high_restores_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      raw_i |=> good_o);

endmodule

// File: rtl/rseq_rail_timer.sv
module rseq_rail_timer
   import rseq_pkg::*;
#(
   parameter int unsigned  DW       = 16,
   parameter logic [DW-1:0] ON_CYC  = '0,
   parameter logic [DW-1:0] OFF_CYC = '0,
   parameter logic [DW-1:0] RAMP_CYC = '0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic go_on_i,
   input  logic go_off_i,
   input  logic kill_i,
   output logic gate_o,
   output logic full_o,
   output logic off_o,
   output logic dis_o
);

   ch_st_t        st_q;
   logic [DW-1:0] cnt_q;
   logic [DW-1:0] on_q, off_q, ramp_q;
   logic          dis_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= CH_OFF;
         cnt_q  <= '0;
         dis_q  <= 1'b0;
         on_q   <= ON_CYC;
         off_q  <= OFF_CYC;
         ramp_q <= RAMP_CYC;
      end else if (kill_i) begin
         st_q  <= CH_OFF;
         dis_q <= 1'b1;
      end else if (go_off_i) begin
         unique case (st_q)
            CH_RAMP, CH_FULL: begin
               st_q  <= CH_WAIT_OFF;
               cnt_q <= off_q;
            end
            CH_WAIT_ON: st_q <= CH_OFF;
            default: ;
         endcase
      end else if (go_on_i) begin
         if (st_q == CH_OFF) begin
            st_q  <= CH_WAIT_ON;
            cnt_q <= on_q;
            dis_q <= 1'b0;
         end
      end else begin
         unique case (st_q)
            CH_WAIT_ON: begin
               if (cnt_q == '0) begin
                  st_q  <= CH_RAMP;
                  cnt_q <= ramp_q;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            CH_RAMP: begin
               if (cnt_q == '0) st_q <= CH_FULL;
               else             cnt_q <= cnt_q - 1'b1;
            end
            CH_WAIT_OFF: begin
               if (cnt_q == '0) st_q <= CH_OFF;
               else             cnt_q <= cnt_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign gate_o = (st_q == CH_RAMP) || (st_q == CH_FULL) || (st_q == CH_WAIT_OFF);
   assign full_o = (st_q == CH_FULL);
   assign off_o  = (st_q == CH_OFF);
   assign dis_o  = dis_q;

   assert_kill_drops_gate_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      kill_i |=> (!gate_o && dis_o));

   assert_rise_after_wait_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_o) |-> $past(st_q == CH_WAIT_ON));

   assert_waiting_never_rises_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == CH_WAIT_ON && go_off_i && !kill_i) |=> !gate_o);

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
   import rseq_pkg::*;
#(
   parameter int unsigned NCH         = 4,
   parameter int unsigned DW          = 16,
   parameter int unsigned CLK_KHZ     = 50000,
   parameter int unsigned QUAL_CYC    = CLK_KHZ * 10,
   parameter int unsigned SETTLE_CYC  = CLK_KHZ * 160,
   parameter int unsigned FILT_CYC    = (CLK_KHZ * 7 + 999) / 1000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EN_ACTIVE_LOW = 1'b0,
   parameter logic [NCH*DW-1:0] ON_DLY   = {NCH{DW'(2000)}},
   parameter logic [NCH*DW-1:0] OFF_DLY  = {NCH{DW'(2000)}},
   parameter logic [NCH*DW-1:0] RAMP_DLY = {NCH{DW'(500)}}
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           en_i,
   input  logic [NCH-1:0] uv_ok_i,
   input  logic           sysrst_sense_i,
   output logic [NCH-1:0] gate_o,
   output logic [NCH-1:0] dis_o,
   output logic           sysrst_pd_o,
   output logic           seq_rst_no
);

   localparam int unsigned TMAX = (QUAL_CYC > SETTLE_CYC) ? QUAL_CYC : SETTLE_CYC;
   localparam int unsigned TW   = $clog2(TMAX + 1);
   localparam int unsigned SW   = NCH + 2;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("rail_sequencer: NCH must be at least 1");
      end
      if (QUAL_CYC <= SYNC_STAGES + 3) begin : g_bad_qual
         $error("rail_sequencer: QUAL_CYC must exceed the line sense latency");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("rail_sequencer: SETTLE_CYC must be at least 1");
      end
   endgenerate

   // input synchronisation
   logic [SW-1:0] raw_in, syn_in;
   logic          en_s, sys_s;
   logic [NCH-1:0] uv_s, uv_f;

   assign raw_in = {sysrst_sense_i, uv_ok_i, en_i};

   rseq_sync #(
      .W      (SW),
      .STAGES (SYNC_STAGES),
      .RST_VAL({1'b0, {NCH{1'b0}}, EN_ACTIVE_LOW})
   ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   assign en_s  = syn_in[0];
   assign uv_s  = syn_in[NCH:1];
   assign sys_s = syn_in[NCH+1];

   // polarity selection
   logic en_ok;
   generate
      if (EN_ACTIVE_LOW) begin : g_en_low
         assign en_ok = !en_s;
      end else begin : g_en_high
         assign en_ok = en_s;
      end
   endgenerate

   // per-rail glitch filters and timers
   logic           go_on_q, go_off_q, kill;
   logic [NCH-1:0] full_v, off_v;

   for (genvar c = 0; c < NCH; c++) begin : g_rail
      rseq_uv_filter #(.FILT_CYC(FILT_CYC)) u_filt (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .raw_i (uv_s[c]),
         .good_o(uv_f[c])
      );

      rseq_rail_timer #(
         .DW      (DW),
         .ON_CYC  (ON_DLY[c*DW +: DW]),
         .OFF_CYC (OFF_DLY[c*DW +: DW]),
         .RAMP_CYC(RAMP_DLY[c*DW +: DW])
      ) u_tmr (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .go_on_i (go_on_q),
         .go_off_i(go_off_q),
         .kill_i  (kill),
         .gate_o  (gate_o[c]),
         .full_o  (full_v[c]),
         .off_o   (off_v[c]),
         .dis_o   (dis_o[c])
      );
   end

   // sequencing state machine
   seq_st_t       st_q;
   logic [TW-1:0] tmr_q;
   logic          uv_all, all_full, all_off, cond, on_phase, trip;

   assign uv_all   = &uv_f;
   assign all_full = &full_v;
   assign all_off  = &off_v;
   assign cond     = en_ok && uv_all;
   assign on_phase = (st_q == SQ_STAGGER) || (st_q == SQ_SETTLE) || (st_q == SQ_RUN);
   assign trip     = (!uv_all || !sys_s) && (on_phase || (st_q == SQ_DRAIN && !all_off));
   assign kill     = trip || (st_q == SQ_TRIP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= SQ_IDLE;
         tmr_q    <= '0;
         go_on_q  <= 1'b0;
         go_off_q <= 1'b0;
      end else begin
         go_on_q  <= 1'b0;
         go_off_q <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               if (cond) begin
                  tmr_q <= '0;
                  if (sys_s) begin
                     st_q    <= SQ_STAGGER;
                     go_on_q <= 1'b1;
                  end else begin
                     st_q <= SQ_QUAL;
                  end
               end
            end
            SQ_QUAL: begin
               if (!en_ok) begin
                  st_q     <= SQ_DRAIN;
                  go_off_q <= 1'b1;
               end else if (!uv_all) begin
                  st_q <= SQ_IDLE;
               end else if (tmr_q == TW'(QUAL_CYC - 1)) begin
                  st_q    <= SQ_STAGGER;
                  go_on_q <= 1'b1;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            SQ_STAGGER: begin
               if (trip) begin
                  st_q <= SQ_TRIP;
               end else if (!en_ok) begin
                  st_q     <= SQ_DRAIN;
                  go_off_q <= 1'b1;
               end else if (all_full) begin
                  st_q  <= SQ_SETTLE;
                  tmr_q <= '0;
               end
            end
            SQ_SETTLE: begin
               if (trip) begin
                  st_q <= SQ_TRIP;
               end else if (!en_ok) begin
                  st_q     <= SQ_DRAIN;
                  go_off_q <= 1'b1;
               end else if (tmr_q == TW'(SETTLE_CYC - 1)) begin
                  st_q <= SQ_RUN;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            SQ_RUN: begin
               if (trip) begin
                  st_q <= SQ_TRIP;
               end else if (!en_ok) begin
                  st_q     <= SQ_DRAIN;
                  go_off_q <= 1'b1;
               end
            end
            SQ_DRAIN: begin
               if (trip)                       st_q <= SQ_TRIP;
               else if (all_off && !go_off_q)  st_q <= SQ_IDLE;
            end
            SQ_TRIP: begin
               if (!en_ok) st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign seq_rst_no = (st_q == SQ_RUN);

   always_comb begin
      unique case (st_q)
         SQ_QUAL, SQ_STAGGER, SQ_SETTLE, SQ_RUN: sysrst_pd_o = 1'b0;
         SQ_DRAIN:                               sysrst_pd_o = all_off;
         default:                                sysrst_pd_o = 1'b1;
      endcase
   end

   assert_no_gate_in_qual_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == SQ_QUAL) |-> (gate_o == '0));

   assert_done_needs_full_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      seq_rst_no |-> all_full);

   assert_fault_drops_all_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == SQ_RUN && !uv_all) |=> (gate_o == '0 && !seq_rst_no && sysrst_pd_o));

   assert_done_falls_first_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == SQ_RUN && !en_ok && uv_all && sys_s) |=> (!seq_rst_no && gate_o == '1));

   assert_line_low_kills_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == SQ_RUN && !sys_s) |=> (gate_o == '0));

   assert_trip_holds_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == SQ_TRIP && en_ok) |=> (gate_o == '0 && sysrst_pd_o));

endmodule

// File: tb/tb_rail_sequencer.sv
module tb_rail_sequencer;

   localparam int NCH = 4;
   localparam int QUAL = 80;
   localparam int SETTLE = 60;
   localparam int FILT = 6;
   localparam int ON  [4] = '{10, 30, 20, 50};
   localparam int OFF [4] = '{40, 10, 25, 5};
   localparam int RMP [4] = '{4, 6, 8, 5};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic ext_low = 1'b0;
   logic force_hi = 1'b0;
   logic [3:0] uv = 4'hF;
   logic line;
   logic [3:0] gate, dis;
   logic pd, done_n;

   logic en_al = 1'b1;
   logic line_al;
   logic [3:0] gate_al, dis_al;
   logic pd_al, done_al;

   assign line    = force_hi | !(pd | ext_low);
   assign line_al = !pd_al;

   always #10 clk = ~clk;

   rail_sequencer #(
      .NCH(NCH), .DW(16), .QUAL_CYC(QUAL), .SETTLE_CYC(SETTLE), .FILT_CYC(FILT),
      .SYNC_STAGES(2), .EN_ACTIVE_LOW(1'b0),
      .ON_DLY  ({16'd50, 16'd20, 16'd30, 16'd10}),
      .OFF_DLY ({16'd5, 16'd25, 16'd10, 16'd40}),
      .RAMP_DLY({16'd5, 16'd8, 16'd6, 16'd4})
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uv_ok_i(uv), .sysrst_sense_i(line),
      .gate_o(gate), .dis_o(dis), .sysrst_pd_o(pd), .seq_rst_no(done_n)
   );

   rail_sequencer #(
      .NCH(NCH), .DW(16), .QUAL_CYC(QUAL), .SETTLE_CYC(SETTLE), .FILT_CYC(FILT),
      .SYNC_STAGES(2), .EN_ACTIVE_LOW(1'b1),
      .ON_DLY  ({16'd50, 16'd20, 16'd30, 16'd10}),
      .OFF_DLY ({16'd5, 16'd25, 16'd10, 16'd40}),
      .RAMP_DLY({16'd5, 16'd8, 16'd6, 16'd4})
   ) dut_al (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en_al), .uv_ok_i(4'hF), .sysrst_sense_i(line_al),
      .gate_o(gate_al), .dis_o(dis_al), .sysrst_pd_o(pd_al), .seq_rst_no(done_al)
   );

   // edge monitor
   int cyc = 0;
   int rise_t [4] = '{-1, -1, -1, -1};
   int fall_t [4] = '{-1, -1, -1, -1};
   int done_rise = -1, done_fall = -1, pd_rise = -1;
   logic [3:0] g_prev = 4'h0;
   logic d_prev = 1'b0, p_prev = 1'b1;

   always @(posedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (gate[i] && !g_prev[i]) rise_t[i] = cyc;
         if (!gate[i] && g_prev[i]) fall_t[i] = cyc;
      end
      if (done_n && !d_prev) done_rise = cyc;
      if (!done_n && d_prev) done_fall = cyc;
      if (pd && !p_prev) pd_rise = cyc;
      g_prev = gate;
      d_prev = done_n;
      p_prev = pd;
      cyc = cyc + 1;
   end

   int n_chk = 0, n_err = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      wait_n(3);
      chk(gate == 0 && dis == 0, "R1", "outputs in reset", int'({gate, dis}), 0);
      chk(done_n == 0 && pd == 1, "R1", "reset/pd in reset", int'({done_n, pd}), 1);
      rst_n = 1'b1;
      wait_n(2);
      chk(gate == 0 && done_n == 0 && pd == 1, "R1", "after reset", int'({gate, done_n, pd}), 1);
   endtask

   task automatic t_power_on(input string req);
      int t0, lf, d;
      en = 1'b1;
      t0 = cyc;
      wait_n(5);
      chk(pd == 0, "R2", "line released", int'(pd), 0);
      chk(gate == 0, "R2", "no early gate", int'(gate), 0);
      wait_n(QUAL + 50 + 5 + SETTLE + 40);
      chk(rise_t[0] - t0 >= QUAL, "R2", "qualify wait", rise_t[0] - t0, QUAL);
      for (int i = 1; i < 4; i++)
         chk(rise_t[i] - rise_t[0] == ON[i] - ON[0], "R3", "stagger offset",
             rise_t[i] - rise_t[0], ON[i] - ON[0]);
      lf = 0;
      for (int i = 1; i < 4; i++) if (ON[i] + RMP[i] > ON[lf] + RMP[lf]) lf = i;
      d = done_rise - rise_t[lf];
      chk(done_rise > t0 && d >= RMP[lf] + SETTLE && d <= RMP[lf] + SETTLE + 5, "R4",
          "settle window", d, RMP[lf] + SETTLE);
      chk(done_n == 1 && gate == 4'hF, req, "running", int'({done_n, gate}), 31);
      chk(dis == 0, req, "discharge cleared", int'(dis), 0);
   endtask

   task automatic t_glitch();
      uv[1] = 1'b0;
      wait_n(FILT - 1);
      uv[1] = 1'b1;
      wait_n(20);
      chk(gate == 4'hF && done_n == 1, "R5", "short low ignored", int'({gate, done_n}), 31);
      chk(dis == 0, "R5", "no discharge", int'(dis), 0);
   endtask

   task automatic t_shutdown();
      int t0, mx;
      t0 = cyc;
      en = 1'b0;
      wait_n(80);
      mx = fall_t[0];
      for (int i = 0; i < 4; i++) begin
         chk(done_fall >= t0 && done_fall < fall_t[i], "R7", "reset before gate",
             done_fall, fall_t[i] - 1);
         if (fall_t[i] > mx) mx = fall_t[i];
      end
      for (int i = 1; i < 4; i++)
         chk(fall_t[i] - fall_t[0] == OFF[i] - OFF[0], "R7", "off offset",
             fall_t[i] - fall_t[0], OFF[i] - OFF[0]);
      chk(pd_rise == mx, "R7", "line pull with last gate", pd_rise, mx);
      chk(gate == 0 && pd == 1, "R7", "all off", int'({gate, pd}), 1);
   endtask

   task automatic t_fault();
      int t0;
      t0 = cyc;
      uv[2] = 1'b0;
      wait_n(FILT + 10);
      chk(gate == 0 && done_n == 0 && pd == 1, "R6", "fault state", int'({gate, done_n, pd}), 1);
      chk(dis == 4'hF, "R6", "discharge all", int'(dis), 15);
      chk(fall_t[0] - t0 >= FILT, "R6", "filter delay", fall_t[0] - t0, FILT);
      for (int i = 1; i < 4; i++)
         chk(fall_t[i] == fall_t[0], "R6", "simultaneous gates", fall_t[i], fall_t[0]);
      chk(done_fall == fall_t[0] && pd_rise == fall_t[0], "R6", "simultaneous reset/line",
          done_fall, fall_t[0]);
      uv[2] = 1'b1;
      wait_n(150);
      chk(gate == 0 && done_n == 0, "R12", "latched off", int'({gate, done_n}), 0);
      en = 1'b0;
      wait_n(10);
      t_power_on("R12");
   endtask

   task automatic t_extkill();
      ext_low = 1'b1;
      wait_n(8);
      chk(gate == 0 && done_n == 0, "R8", "line low kills", int'({gate, done_n}), 0);
      ext_low = 1'b0;
      en = 1'b0;
      wait_n(30);
      chk(gate == 0 && pd == 1, "R8", "stays off", int'({gate, pd}), 1);
   endtask

   task automatic t_skip();
      int t0;
      force_hi = 1'b1;
      wait_n(5);
      en = 1'b1;
      t0 = cyc;
      wait_n(ON[0] + 20);
      chk(rise_t[0] > t0 && rise_t[0] - t0 < QUAL, "R9", "qualify skipped", rise_t[0] - t0, ON[0]);
      force_hi = 1'b0;
      wait_n(60 + SETTLE + 20);
      chk(done_n == 1, "R9", "runs after skip", int'(done_n), 1);
      en = 1'b0;
      wait_n(80);
   endtask

   task automatic t_abort();
      int t0, tries;
      en = 1'b1;
      t0 = cyc;
      tries = 0;
      while (!gate[2] && tries < 400) begin
         wait_n(1);
         tries++;
      end
      en = 1'b0;
      wait_n(120);
      chk(rise_t[0] > t0 && rise_t[2] > t0, "R11", "early gates rose", rise_t[2], t0);
      chk(rise_t[1] <= t0 && rise_t[3] <= t0, "R11", "late gates never rose", rise_t[1], t0);
      chk(fall_t[0] > t0 && fall_t[2] > t0, "R11", "early gates fell", fall_t[0], t0);
      chk(gate == 0 && pd == 1, "R11", "drained", int'({gate, pd}), 1);
   endtask

   task automatic t_polarity();
      wait_n(20);
      chk(pd_al == 1 && gate_al == 0, "R10", "input high is inactive", int'(pd_al), 1);
      en_al = 1'b0;
      wait_n(6);
      chk(pd_al == 0, "R10", "input low is active", int'(pd_al), 0);
   endtask

   initial begin
      t_reset();
      t_polarity();
      t_power_on("R2");
      t_glitch();
      t_shutdown();
      t_power_on("R3");
      t_fault();
      t_extkill();
      t_skip();
      t_abort();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule